// File: doc/BRIEF.md
# Configuration CRC Checksum Monitor

This block guards a set of protected configuration registers by computing a CRC-32 over a fixed 256-bit image of them. The image is captured when a computation starts. It is then fed one bit per clock, least significant bit first, into a linear feedback shift register that starts with every bit set to one. The polynomial is the common Ethernet CRC-32 generator, and no final inversion or bit reversal is applied. When all 256 bits have passed through, the state is stored as the published checksum. The state after the first 48 bits is published separately as an intermediate CRC. Those 48 bits are the six 8-bit internal registers that enter first.

Each new checksum is compared with the one before it. A mismatch means a protected register has drifted, and the block raises a sticky change flag, which software clears with a clear strobe. When reset is released, the block starts a computation on its own over whatever image is present (the default register values), so a valid checksum is available without any software action. A start strobe requests every later computation.

Top module: `cfg_crc_monitor`

## Requirements
- R1: The LFSR state is all ones when a computation starts. Each step computes fb = bit XOR state[31], then the new state is (state << 1) XOR (fb ? 32'h04C11DB7 : 0). Image bit 0 is consumed first and bit 255 last. `checksum_o` holds the state after step 256, with no final XOR or reversal.
- R2: `mid_crc_o` holds the LFSR state after step 48, that is, after image bits 0..47.
- R3: The image is captured in the cycle a start is accepted. Later changes on `image_i` have no effect on that computation's results.
- R4: Once a start is accepted, `busy_o` is high for exactly 256 cycles. `done_o` is then high for exactly one cycle, the first cycle with `busy_o` low. Both checksum outputs are updated when `done_o` rises.
- R5: A `start_i` pulse while `busy_o` is high is ignored. The run neither restarts nor lengthens.
- R6: After reset is released, a computation on the current image starts by itself at the first clock edge, without any `start_i`.
- R7: `chg_o` rises in the cycle after `done_o` when the new checksum differs from the previous one. It stays low if the two are equal and the flag was clear.
- R8: The first computation after reset never sets `chg_o`.
- R9: `chg_o` stays high across later runs until `clr_chg_i` is pulsed. It then reads 0 in the following cycle, unless a mismatch is detected in that same cycle.
- R10: While `rst_n` is low, `busy_o`, `done_o` and `chg_o` are 0, and `checksum_o` and `mid_crc_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request a new computation (ignored while busy) |
| clr_chg_i | input | 1 | Clear the sticky change flag |
| image_i | input | 256 | Concatenated protected register image, bit 0 enters first |
| busy_o | output | 1 | Computation in progress |
| done_o | output | 1 | One-cycle pulse when a computation completes |
| checksum_o | output | 32 | CRC after all 256 bits |
| mid_crc_o | output | 32 | CRC after the first 48 bits |
| chg_o | output | 1 | Sticky flag: the latest checksum differs from the previous one |

## Verification
The bench targets the bit order and the step-48 capture by using images that differ only in bit 255, or only in the low 48 bits. A design that consumed bits MSB first, or captured the intermediate CRC one step off, would publish values that disagree with an independent per-bit model. It disturbs both the image and the start strobe halfway through a run. Missing the snapshot would corrupt the checksum, and accepting the restart would stretch busy past 256 cycles. It also repeats identical images and clears the flag. A design that compared against a zero initial value would flag the first run, and one whose flag was not sticky would drop it on a matching rerun.

// File: rtl/cfg_crc_pkg.sv
package cfg_crc_pkg;
  localparam int CRC_W = 32;
  localparam logic [CRC_W-1:0] CRC_POLY = 32'h04C11DB7;
  localparam logic [CRC_W-1:0] CRC_SEED = '1;

  typedef logic [CRC_W-1:0] crc_t;

  // One serial LFSR step: feedback from input bit and state MSB.
  function automatic crc_t crc_step(input crc_t s, input logic a);
    logic fb;
    fb = a ^ s[CRC_W-1];
    return {s[CRC_W-2:0], 1'b0} ^ ({CRC_W{fb}} & CRC_POLY);
  endfunction
endpackage

// File: rtl/crc_seq_ctrl.sv
module crc_seq_ctrl #(
  parameter int STEPS    = 256,
  parameter int MID_STEP = 48
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic go_o,
  output logic step_o,
  output logic cap_mid_o,
  output logic last_o,
  output logic busy_o,
  output logic done_o
);
  localparam int CW = (STEPS > 1) ? $clog2(STEPS) : 1;
  localparam logic [CW-1:0] LAST_IDX = CW'(STEPS - 1);
  localparam logic [CW-1:0] MID_IDX  = CW'(MID_STEP - 1);

  logic          busy_q;
  logic          done_q;
  logic          auto_q;
  logic [CW-1:0] cnt_q;

  assign go_o      = !busy_q && (start_i || auto_q);
  assign step_o    = busy_q;
  assign last_o    = busy_q && (cnt_q == LAST_IDX);
  assign cap_mid_o = busy_q && (cnt_q == MID_IDX);
  assign busy_o    = busy_q;
  assign done_o    = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      auto_q <= 1'b1;
      cnt_q  <= '0;
    end else begin
      done_q <= last_o;
      if (go_o) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
        auto_q <= 1'b0;
      end else if (busy_q) begin
        if (last_o) busy_q <= 1'b0;
        else        cnt_q  <= cnt_q + 1'b1;
      end
    end
  end

  // R4
  final_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_o |=> (!busy_o && done_o));
  // R4
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  // R5
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !last_o) |=> (busy_o && cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/crc_lfsr_core.sv
module crc_lfsr_core
  import cfg_crc_pkg::*;
#(
  parameter int IMG_W = 256
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go_i,
  input  logic             step_i,
  input  logic [IMG_W-1:0] image_i,
  output crc_t             state_o,
  output crc_t             next_o
);
  logic [IMG_W-1:0] sh_q;
  crc_t             st_q;

  assign state_o = st_q;
  assign next_o  = crc_step(st_q, sh_q[0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
      st_q <= CRC_SEED;
    end else if (go_i) begin
      sh_q <= image_i;
      st_q <= CRC_SEED;
    end else if (step_i) begin
      sh_q <= {1'b0, sh_q[IMG_W-1:1]};
      st_q <= next_o;
    end
  end

  // R1
  seed_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go_i |=> (state_o == CRC_SEED));
endmodule

// File: rtl/crc_change_det.sv
module crc_change_det
  import cfg_crc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic done_i,
  input  crc_t sum_i,
  input  logic clr_i,
  output logic chg_o
);
  crc_t prev_q;
  logic have_q;
  logic chg_q;
  logic mismatch;

  assign mismatch = done_i && have_q && (sum_i != prev_q);
  assign chg_o    = chg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      have_q <= 1'b0;
      chg_q  <= 1'b0;
    end else begin
      if (done_i) begin
        prev_q <= sum_i;
        have_q <= 1'b1;
      end
      if (mismatch)   chg_q <= 1'b1;
      else if (clr_i) chg_q <= 1'b0;
    end
  end

  // R8
  first_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!have_q && !chg_q) |=> !chg_o);
  // R9
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chg_o && !clr_i) |=> chg_o);
endmodule

// File: rtl/cfg_crc_monitor.sv
module cfg_crc_monitor
  import cfg_crc_pkg::*;
#(
  parameter int IMG_W    = 256,
  parameter int MID_BITS = 48
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             clr_chg_i,
  input  logic [IMG_W-1:0] image_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [31:0]      checksum_o,
  output logic [31:0]      mid_crc_o,
  output logic             chg_o
);
  logic go, step, cap_mid, last;
  crc_t lfsr_state, lfsr_next;
  crc_t sum_q, mid_q;

  crc_seq_ctrl #(.STEPS(IMG_W), .MID_STEP(MID_BITS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .go_o(go), .step_o(step), .cap_mid_o(cap_mid), .last_o(last),
    .busy_o(busy_o), .done_o(done_o)
  );

  crc_lfsr_core #(.IMG_W(IMG_W)) u_lfsr (
    .clk(clk), .rst_n(rst_n), .go_i(go), .step_i(step),
    .image_i(image_i), .state_o(lfsr_state), .next_o(lfsr_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q <= '0;
      mid_q <= '0;
    end else begin
      if (last)    sum_q <= lfsr_next;
      if (cap_mid) mid_q <= lfsr_next;
    end
  end

  assign checksum_o = sum_q;
  assign mid_crc_o  = mid_q;

  crc_change_det u_chg (
    .clk(clk), .rst_n(rst_n), .done_i(done_o), .sum_i(sum_q),
    .clr_i(clr_chg_i), .chg_o(chg_o)
  );

  // R1
  final_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> (checksum_o == lfsr_state));
  // R2
  mid_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_mid |=> (mid_crc_o == lfsr_state));
  // R4
  stable_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !last) |=> $stable(checksum_o));
endmodule

// File: tb/sim_cfg_crc_monitor.sv
module sim_cfg_crc_monitor;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic clr = 1'b0;
  logic [255:0] image = '0;
  logic busy, done, chg;
  logic [31:0] sum, mid;

  int checks = 0;
  int errors = 0;

  typedef struct { logic [31:0] sum; logic [31:0] mid; } exp_t;
  exp_t sb[$];

  always #10 clk = ~clk;

  cfg_crc_monitor u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start), .clr_chg_i(clr),
    .image_i(image), .busy_o(busy), .done_o(done), .checksum_o(sum),
    .mid_crc_o(mid), .chg_o(chg)
  );

  // Independent model: per-bit equations with explicit coefficient list.
  function automatic exp_t model(input logic [255:0] img);
    logic [31:0] g, b, nb;
    logic fb;
    exp_t r;
    int taps[14] = '{0, 1, 2, 4, 5, 7, 8, 10, 11, 12, 16, 22, 23, 26};
    g = '0;
    foreach (taps[k]) g[taps[k]] = 1'b1;
    b = 32'hFFFF_FFFF;
    r.mid = '0;
    for (int j = 1; j <= 256; j++) begin
      fb = img[j-1] ^ b[31];
      nb[0] = fb & g[0];
      for (int i = 1; i < 32; i++) nb[i] = (fb & g[i]) ^ b[i-1];
      b = nb;
      if (j == 48) r.mid = b;
    end
    r.sum = b;
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Monitor: pops expected results when done pulses.
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (sb.size() == 0) begin
        chk(1'b0, "R1 unexpected done", sum, 32'h0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk(sum == e.sum, "R1 checksum", sum, e.sum);
        chk(mid == e.mid, "R2 mid crc", mid, e.mid);
      end
    end
  end

  // Waits for done, counting busy cycles; optional mid-run disturbance.
  task automatic wait_run(input bit disturb, output int nbusy);
    nbusy = 0;
    forever begin
      @(negedge clk);
      start = 1'b0;
      if (busy) nbusy++;
      if (disturb && nbusy == 100) begin
        image = ~image;
        start = 1'b1;
      end
      if (done || nbusy > 400) break;
    end
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run(input logic [255:0] v, input bit disturb, input string req);
    int n;
    @(negedge clk);
    image = v;
    sb.push_back(model(v));
    start = 1'b1;
    wait_run(disturb, n);
    chk(n == 256, req, 32'(n), 32'd256);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog timeout actual=hung expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [255:0] img0, img1, img2;
    int n;
    img0 = {64'h0123_4567_89AB_CDEF, 64'h0, 64'hDEAD_BEEF_0000_FFFF, 64'h1122_3344_5566_7788};
    img1 = img0 ^ (256'b1 << 255);
    img2 = img0 ^ 256'h5;

    image = img0;
    repeat (3) @(negedge clk);
    // R10 reset values
    chk(!busy && !done && !chg, "R10 control outputs in reset", {busy, done, chg}, 32'h0);
    chk(sum == 0 && mid == 0, "R10 crc outputs in reset", sum, 32'h0);

    // R6 automatic run after reset
    sb.push_back(model(img0));
    rst_n = 1'b1;
    wait_run(1'b0, n);
    chk(n == 256, "R6 auto run busy length", 32'(n), 32'd256);
    chk(!chg, "R8 first run leaves flag clear", {31'b0, chg}, 32'h0);

    // R3/R5 disturbance during run, same image: no change
    run(img0, 1'b1, "R5 busy length with start while busy");
    chk(!chg, "R7 equal checksum keeps flag clear", {31'b0, chg}, 32'h0);
    chk(!busy, "R5 no restart after done", {31'b0, busy}, 32'h0);

    // R7 differ only in bit 255 (last bit consumed)
    run(img1, 1'b0, "R4 busy length");
    chk(chg, "R7 differing checksum sets flag", {31'b0, chg}, 32'h1);

    // R9 sticky across matching run
    run(img1, 1'b0, "R4 busy length");
    chk(chg, "R9 flag sticky", {31'b0, chg}, 32'h1);
    @(negedge clk) clr = 1'b1;
    @(negedge clk) clr = 1'b0;
    chk(!chg, "R9 clear drops flag", {31'b0, chg}, 32'h0);

    // R2 change only in first 48 bits
    run(img2, 1'b0, "R4 busy length");
    chk(chg, "R7 low-bit change sets flag", {31'b0, chg}, 32'h1);

    run('1, 1'b0, "R4 busy length all ones");
    run('0, 1'b0, "R4 busy length all zeros");

    @(negedge clk);
    chk(sb.size() == 0, "R4 every run produced done", 32'(sb.size()), 32'h0);
    chk(!done, "R4 done is a single pulse", {31'b0, done}, 32'h0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule